// File: doc/BRIEF.md
# Clocked Insertion Sorter

This block keeps a small register array and sorts a prefix of it into non-increasing order by insertion sort, one outer step per clock. A host writes entries through a write port while the sorter is not running, gives a run length and pulses a start input. On each clock of a pass, the entry at the current outer position is lifted out. It is then placed among the already ordered entries in front of it. The outer loop is a clocked counter, and the inner search is unrolled over the compile-time maximum, so the hardware is fixed while the length varies per pass.

The length is captured on the start pulse and clamped to the compile-time maximum. A pass over `L` entries takes `L-1` clocks. The done flag then rises and stays high until the next accepted write or start. Any entry can be read at any time through a combinational read port.

Top module: `insertion_sorter`

## Requirements
- R1: After synchronous reset, busy and done are low and every entry reads back as 0.
- R2: A write with wrEn high while busy is low and start is low stores wrData at wrAddr. The value appears on rdData, for that address, after the clock edge.
- R3: start samples lenIn as the pass length. When that length is 2 or more, busy is high for exactly length-1 clocks after the start edge. done rises on the clock that ends the last step.
- R4: Each step inserts the entry at the outer position (0-based, beginning at 1) into the entries before it. At the end of a pass, entries 0 to length-1 are in non-increasing unsigned order and hold the same values as before.
- R5: Entries at positions at or above the pass length are not changed by a pass.
- R6: A sampled length of 0 or 1 sets done on the next clock, with busy never high and no entry changed.
- R7: wrEn is ignored while busy is high. start also takes priority over wrEn in the same cycle.
- R8: done stays high until an accepted write or a start pulse, and an accepted write clears it.
- R9: A start pulse during a pass abandons that pass. It restarts at outer position 1 with the newly sampled length, keeping the entries as they are.
- R10: A lenIn larger than MAX_LEN is treated as MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for loading an entry |
| wrAddr | input | IDX_W | Entry index for writes |
| wrData | input | DATA_W | Entry value for writes |
| lenIn | input | IDX_W+1 | Runtime pass length, sampled on start |
| start | input | 1 | Begin a pass (single-cycle pulse) |
| rdAddr | input | IDX_W | Entry index for reads |
| rdData | output | DATA_W | Entry value at rdAddr (combinational) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | The last pass finished |

## Verification
The assertions assume that start arrives as a single-cycle pulse and that the write and read addresses stay below MAX_LEN. They also assume that, at every step, the entries before the outer position are already ordered, which holds only because each pass begins at position 1. The stimulus follows these assumptions: start is raised for one clock, and addresses are drawn from 0 to MAX_LEN-1. Writes are attempted during a pass only to test that they are ignored. A restart during a pass always begins again at position 1, so the ordered-prefix invariant is kept.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} sortState_t;

  typedef struct packed {
    logic step;
    logic load;
  } sortCtl_t;
endpackage

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wrEn,
  input  logic [LEN_W-1:0] lenIn,
  output sortCtl_t         ctl,
  output logic [IDX_W-1:0] outerIdx,
  output logic             busy,
  output logic             done
);
  sortState_t        state;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  lenClamped;
  logic              lastStep;

  assign lenClamped = (lenIn > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : lenIn;
  assign lastStep   = ({1'b0, outerIdx} == (lenReg - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      outerIdx <= IDX_W'(1);
      lenReg   <= '0;
    end else if (start) begin
      lenReg   <= lenClamped;
      outerIdx <= IDX_W'(1);
      state    <= (lenClamped < LEN_W'(2)) ? ST_DONE : ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (lastStep) begin
            outerIdx <= IDX_W'(1);
            state    <= ST_DONE;
          end else begin
            outerIdx <= outerIdx + IDX_W'(1);
          end
        end
        ST_DONE: if (wrEn) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.step = (state == ST_RUN) && !start;
    ctl.load = wrEn && (state != ST_RUN) && !start;
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (outerIdx != '0) && ({1'b0, outerIdx} < lenReg));

  assert_wrap_done_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && lastStep) |=> (done && !busy && outerIdx == IDX_W'(1)));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start && !wrEn) |=> done);

  assert_short_len_R6: assert property (@(posedge clk) disable iff (rst)
    (start && lenClamped < LEN_W'(2)) |=> (done && !busy));
endmodule

// File: rtl/sort_datapath.sv
module sort_datapath
  import sorter_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  sortCtl_t          ctl,
  input  logic [IDX_W-1:0]  outerIdx,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] entries [MAX_LEN];
  logic [DATA_W-1:0] stepNext [MAX_LEN];
  logic [DATA_W-1:0] key;
  logic [MAX_LEN-1:0] aheadOfKey;
  logic [IDX_W-1:0]  insPos;
  logic              wrInRange;
  logic              rdInRange;

  assign key       = entries[outerIdx];
  assign wrInRange = ({1'b0, wrAddr} < (IDX_W+1)'(MAX_LEN));
  assign rdInRange = ({1'b0, rdAddr} < (IDX_W+1)'(MAX_LEN));
  assign rdData    = rdInRange ? entries[rdAddr] : '0;

  // Entries in the ordered prefix that are not below the key stay in front.
  for (genvar k = 0; k < MAX_LEN; k++) begin : g_cmp
    assign aheadOfKey[k] = (IDX_W'(k) < outerIdx) && (entries[k] >= key);
  end

  always_comb begin
    insPos = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      insPos = insPos + IDX_W'(aheadOfKey[k]);
    end
  end

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_next
    if (k == 0) begin : g_first
      assign stepNext[k] = (insPos == '0) ? key : entries[k];
    end else begin : g_rest
      always_comb begin
        if (IDX_W'(k) < insPos)        stepNext[k] = entries[k];
        else if (IDX_W'(k) == insPos)  stepNext[k] = key;
        else if (IDX_W'(k) <= outerIdx) stepNext[k] = entries[k-1];
        else                           stepNext[k] = entries[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < MAX_LEN; k++) entries[k] <= '0;
    end else if (ctl.step) begin
      for (int k = 0; k < MAX_LEN; k++) entries[k] <= stepNext[k];
    end else if (ctl.load && wrInRange) begin
      entries[wrAddr] <= wrData;
    end
  end

  assert_no_load_in_step_R7: assert property (@(posedge clk) disable iff (rst)
    !(ctl.load && ctl.step));

  for (genvar k = 0; k < MAX_LEN - 1; k++) begin : g_chk
    assert_prefix_sorted_R4: assert property (@(posedge clk) disable iff (rst)
      (ctl.step && (IDX_W'(k + 1) < outerIdx)) |-> (entries[k] >= entries[k+1]));
  end
endmodule

// File: rtl/insertion_sorter.sv
module insertion_sorter
  import sorter_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 16,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              start,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done
);
  sortCtl_t         ctl;
  logic [IDX_W-1:0] outerIdx;

  sort_ctrl #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .wrEn(wrEn), .lenIn(lenIn),
    .ctl(ctl), .outerIdx(outerIdx), .busy(busy), .done(done)
  );

  sort_datapath #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .outerIdx(outerIdx),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/insertion_sorter_bench.sv
module insertion_sorter_bench;
  localparam int CLK_P   = 10;
  localparam int DATA_W  = 8;
  localparam int MAX_LEN = 16;
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int LEN_W   = IDX_W + 1;
  localparam int WDOG    = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [IDX_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [LEN_W-1:0] lenIn = '0;
  logic start = 1'b0;
  logic [IDX_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic busy, done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R1";

  // behavioural reference
  int mArr [MAX_LEN];
  bit mBusy = 0, mDone = 0;
  int mIdx = 1, mLen = 0;

  insertion_sorter #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_insertion_sorter (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lenIn(lenIn), .start(start), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mArr[i]) mArr[i] = 0;
      mBusy = 0; mDone = 0; mIdx = 1; mLen = 0;
    end else if (start) begin
      mLen = (int'(lenIn) > MAX_LEN) ? MAX_LEN : int'(lenIn);
      mIdx = 1;
      mBusy = (mLen >= 2);
      mDone = (mLen < 2);
    end else if (mBusy) begin
      int key, j;
      key = mArr[mIdx];
      j = mIdx;
      while (j > 0 && mArr[j-1] < key) begin
        mArr[j] = mArr[j-1];
        j--;
      end
      mArr[j] = key;
      if (mIdx == mLen - 1) begin
        mBusy = 0; mDone = 1; mIdx = 1;
      end else mIdx++;
    end else if (wrEn) begin
      mArr[wrAddr] = int'(wrData);
      mDone = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // compare every clock, away from the edge, sweeping the read address
  initial begin
    int sweep = 0;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      cycles++;
      check("R3 busy", int'(busy), int'(mBusy));
      check("R8 done", int'(done), int'(mDone));
      check({phase, " rdData"}, int'(rdData), mArr[rdAddr]);
      sweep = (sweep + 1) % MAX_LEN;
      rdAddr = IDX_W'(sweep);
      if (cycles >= WDOG) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WDOG);
        summary();
      end
    end
  end

  task automatic load(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = IDX_W'(addr); wrData = DATA_W'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart(int len);
    @(negedge clk);
    start = 1'b1; lenIn = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPass();
    while (mBusy) @(negedge clk);
    idle(MAX_LEN + 2);
  endtask

  initial begin
    // R1: reset state, sweep all entries
    phase = "R1";
    idle(3);
    rst = 1'b0;
    idle(MAX_LEN + 1);

    // R2 R4 R5: partial pass with duplicates; upper entries untouched
    phase = "R2";
    for (int a = 0; a < MAX_LEN; a++) load(a, (a * 37 + 11) % 256);
    load(2, 200); load(4, 200);
    idle(MAX_LEN);
    phase = "R4";
    pulseStart(6);
    phase = "R5";
    waitPass();

    // R8: done holds while idle, then a write clears it
    phase = "R8";
    idle(5);
    load(9, 7);
    idle(3);

    // R10 and R4: length above maximum, ascending data (worst case shifting)
    phase = "R10";
    for (int a = 0; a < MAX_LEN; a++) load(a, a * 3);
    pulseStart(20);
    waitPass();

    // R7: writes during a pass are ignored; start wins over wrEn
    phase = "R7";
    for (int a = 0; a < MAX_LEN; a++) load(a, (a * 91 + 5) % 256);
    pulseStart(MAX_LEN);
    idle(2);
    @(negedge clk); wrEn = 1'b1; wrAddr = 3; wrData = 8'hEE;
    @(negedge clk); wrAddr = 12; wrData = 8'h01;
    @(negedge clk); wrEn = 1'b0;
    waitPass();
    @(negedge clk); start = 1'b1; lenIn = 1; wrEn = 1'b1; wrAddr = 0; wrData = 8'h55;
    @(negedge clk); start = 1'b0; wrEn = 1'b0;
    idle(MAX_LEN);

    // R6: lengths 0 and 1 finish at once
    phase = "R6";
    load(0, 1); load(1, 250);
    pulseStart(0);
    idle(4);
    load(5, 9);
    pulseStart(1);
    idle(MAX_LEN);

    // R9: restart mid-pass with a new length
    phase = "R9";
    for (int a = 0; a < MAX_LEN; a++) load(a, (a * 53 + 17) % 256);
    pulseStart(MAX_LEN);
    idle(4);
    pulseStart(8);
    waitPass();

    // R3: minimum real length
    phase = "R3";
    load(0, 4); load(1, 90);
    pulseStart(2);
    waitPass();

    summary();
  end
endmodule